// File: doc/BRIEF.md
# SMT Single-Tag Issue Queue

This block is the dynamic-scheduling window of a four-thread simultaneous multithreading core. Renamed instructions arrive one per cycle with a thread number, a destination tag and two source tags with ready flags. The queue holds them until their operands are available and then issues one instruction per cycle, always the oldest ready one. Every stored instruction waits on at most one tag. Each storage slot therefore needs a single wakeup comparator for each result bus.

The storage has `ENTRIES` entries, and each entry has two halves, which gives 64 slots at the defaults. A run-time mode input chooses between two policies. In blocking mode an entry holds one instruction in its lower half. In packing mode both halves are used, so two independent instructions share one entry, even when they come from different threads. In both modes the queue refuses an instruction whose two sources are still pending, and dispatch holds it until a result broadcast satisfies one of them. A per-thread flush input removes one thread's instructions in a single cycle.

Top module: `smt_issue_queue`

## Requirements
- R1: After reset the queue is empty, `iss_valid_o` is 0, `mode_pack_o` is 0 (blocking), and an instruction with both sources ready is accepted (`disp_stall_o` = 0).
- R2: In either mode, `disp_stall_o` is 1 when neither source is ready and neither source tag matches a valid broadcast in the same cycle. A same-cycle broadcast match counts as ready.
- R3: In blocking mode the queue holds at most `ENTRIES` instructions, and each one sits in the lower half (even slot index) of an entry. When the queue is full, the next dispatch stalls.
- R4: In packing mode the queue holds up to 2*`ENTRIES` instructions, two per entry, from any mix of threads.
- R5: A stored instruction with a pending tag becomes issuable in the cycle after a broadcast of that tag on either bus (`bc_valid_i[0]` with `bc_tag0_i`, `bc_valid_i[1]` with `bc_tag1_i`). A non-matching broadcast has no effect.
- R6: Each cycle at most one instruction issues, and it is the ready instruction that was dispatched earliest.
- R7: A slot is free in the cycle after its instruction issues, and a dispatch stalled only because the queue was full is accepted in that cycle.
- R8: A change on `mode_pack_i` takes effect, and shows on `mode_pack_o`, only once the queue is empty. Until then, dispatch stalls.
- R9: When `flush_valid_i` is high, every instruction of thread `flush_tid_i` is gone from the next cycle on and never issues. That cycle it is not issued, and a dispatch from that thread stalls. Other threads are unaffected.
- R10: An instruction dispatched with both sources ready appears in the next cycle on `iss_valid_o`, `iss_tid_o` and `iss_dst_o` when it is the only ready one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pack_i | input | 1 | Requested mode: 1 packing, 0 blocking |
| disp_valid_i | input | 1 | Dispatch request |
| disp_tid_i | input | TID_W | Thread of the dispatched instruction |
| disp_dst_i | input | TAG_W | Destination tag |
| disp_src0_i | input | TAG_W | First source tag |
| disp_src0_rdy_i | input | 1 | First source ready |
| disp_src1_i | input | TAG_W | Second source tag |
| disp_src1_rdy_i | input | 1 | Second source ready |
| disp_stall_o | output | 1 | Dispatch refused this cycle |
| bc_valid_i | input | 2 | Valid bits of the two result buses |
| bc_tag0_i | input | TAG_W | Result tag on bus 0 |
| bc_tag1_i | input | TAG_W | Result tag on bus 1 |
| flush_valid_i | input | 1 | Flush request |
| flush_tid_i | input | TID_W | Thread to flush |
| iss_valid_o | output | 1 | An instruction issues this cycle |
| iss_tid_o | output | TID_W | Thread of the issued instruction |
| iss_dst_o | output | TAG_W | Destination tag of the issued instruction |
| mode_pack_o | output | 1 | Mode in force |

## Verification
Some properties are checked on every cycle. The odd slot halves stay empty in blocking mode. Occupancy never exceeds the capacity of the current mode. The mode only changes after an empty cycle. A matching broadcast always marks a waiting slot ready. A flushed thread leaves no slot behind. The bench's scenarios cover what a single-cycle property cannot: the dispatch order behind the oldest-first issue sequence, the exact fill level at which dispatch stalls in each mode, immediate reuse of a slot just freed, and the skipped destinations after a flush.

// File: rtl/smt_issue_queue.sv
module smt_issue_queue #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 6,
  parameter int TID_W   = 2,
  parameter int AGE_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_pack_i,
  input  logic             disp_valid_i,
  input  logic [TID_W-1:0] disp_tid_i,
  input  logic [TAG_W-1:0] disp_dst_i,
  input  logic [TAG_W-1:0] disp_src0_i,
  input  logic             disp_src0_rdy_i,
  input  logic [TAG_W-1:0] disp_src1_i,
  input  logic             disp_src1_rdy_i,
  output logic             disp_stall_o,
  input  logic [1:0]       bc_valid_i,
  input  logic [TAG_W-1:0] bc_tag0_i,
  input  logic [TAG_W-1:0] bc_tag1_i,
  input  logic             flush_valid_i,
  input  logic [TID_W-1:0] flush_tid_i,
  output logic             iss_valid_o,
  output logic [TID_W-1:0] iss_tid_o,
  output logic [TAG_W-1:0] iss_dst_o,
  output logic             mode_pack_o
);
  localparam int SLOTS = 2 * ENTRIES;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [SLOTS-1:0] ODD_HALVES = {ENTRIES{2'b10}};

  logic [SLOTS-1:0] vld, rdy, wake, killed;
  logic [TID_W-1:0] tid  [SLOTS];
  logic [TAG_W-1:0] dst  [SLOTS];
  logic [TAG_W-1:0] ptag [SLOTS];
  logic [AGE_W-1:0] age  [SLOTS];
  logic             mode_q;

  function automatic logic bc_hit(input logic [TAG_W-1:0] t);
    return (bc_valid_i[0] && bc_tag0_i == t) || (bc_valid_i[1] && bc_tag1_i == t);
  endfunction

  for (genvar s = 0; s < SLOTS; s++) begin : g_match
    assign wake[s]   = bc_hit(ptag[s]);
    assign killed[s] = flush_valid_i && tid[s] == flush_tid_i;
  end

  logic s0_ok, s1_ok, new_rdy;
  logic [TAG_W-1:0] new_ptag;
  assign s0_ok    = disp_src0_rdy_i || bc_hit(disp_src0_i);
  assign s1_ok    = disp_src1_rdy_i || bc_hit(disp_src1_i);
  assign new_rdy  = s0_ok && s1_ok;
  assign new_ptag = s0_ok ? disp_src1_i : disp_src0_i;

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (!vld[s] && (mode_q || s % 2 == 0)) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(s);
      end
  end

  assign disp_stall_o = (!s0_ok && !s1_ok) || !free_found || (mode_pack_i != mode_q) ||
                        (flush_valid_i && flush_tid_i == disp_tid_i);
  logic accept;
  assign accept = disp_valid_i && !disp_stall_o;

  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;
  logic [AGE_W-1:0] sel_age;
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    sel_age   = '0;
    for (int s = 0; s < SLOTS; s++)
      if (vld[s] && rdy[s] && !killed[s] && (!sel_found || age[s] > sel_age)) begin
        sel_found = 1'b1;
        sel_idx   = IDX_W'(s);
        sel_age   = age[s];
      end
  end

  assign iss_valid_o = sel_found;
  assign iss_tid_o   = tid[sel_idx];
  assign iss_dst_o   = dst[sel_idx];
  assign mode_pack_o = mode_q;

  logic [CNT_W-1:0] count;
  assign count = CNT_W'($countones(vld));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rdy    <= '0;
      mode_q <= 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        tid[s]  <= '0;
        dst[s]  <= '0;
        ptag[s] <= '0;
        age[s]  <= '0;
      end
    end else begin
      if (vld == '0) mode_q <= mode_pack_i;
      for (int s = 0; s < SLOTS; s++) begin
        if (vld[s]) begin
          if (age[s] != '1) age[s] <= age[s] + 1'b1;
          if (!rdy[s] && wake[s]) rdy[s] <= 1'b1;
          if ((sel_found && sel_idx == IDX_W'(s)) || killed[s]) vld[s] <= 1'b0;
        end else if (accept && free_idx == IDX_W'(s)) begin
          vld[s]  <= 1'b1;
          rdy[s]  <= new_rdy;
          tid[s]  <= disp_tid_i;
          dst[s]  <= disp_dst_i;
          ptag[s] <= new_ptag;
          age[s]  <= '0;
        end
      end
    end
  end

  // R3
  blocking_odd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (vld & ODD_HALVES) == '0);

  // R3 R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (mode_q ? CNT_W'(SLOTS) : CNT_W'(ENTRIES)));

  // R8
  mode_switch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(vld == '0));

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    // R5
    wake_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[s] && !rdy[s] && wake[s] && !killed[s]) |=> (vld[s] && rdy[s]));
    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid_i |=> !(vld[s] && tid[s] == $past(flush_tid_i)));
  end
endmodule

// File: tb/sim_smt_issue_queue.sv
module sim_smt_issue_queue;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic mode_pack_i = 0, disp_valid_i = 0, disp_src0_rdy_i = 0, disp_src1_rdy_i = 0;
  logic [1:0] disp_tid_i = 0, flush_tid_i = 0, iss_tid_o;
  logic [5:0] disp_dst_i = 0, disp_src0_i = 0, disp_src1_i = 0, bc_tag0_i = 0, bc_tag1_i = 0, iss_dst_o;
  logic [1:0] bc_valid_i = 0;
  logic flush_valid_i = 0, disp_stall_o, iss_valid_o, mode_pack_o;

  smt_issue_queue u0 (.*);

  int checks = 0, fails = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic disp(input int t, input int d, input int s0, input logic r0, input int s1, input logic r1);
    disp_valid_i = 1; disp_tid_i = 2'(t); disp_dst_i = 6'(d);
    disp_src0_i = 6'(s0); disp_src0_rdy_i = r0; disp_src1_i = 6'(s1); disp_src1_rdy_i = r1;
    #1;
  endtask

  task automatic bcast(input int bus, input int tg);
    bc_valid_i = 2'b0;
    bc_valid_i[bus] = 1'b1;
    if (bus == 0) bc_tag0_i = 6'(tg); else bc_tag1_i = 6'(tg);
    step();
    bc_valid_i = 2'b0;
  endtask

  task automatic fill(input int n, input int tg);
    for (int i = 0; i < n; i++) begin
      disp(i % 4, i, tg, 0, 0, 1);
      chk(!disp_stall_o, "R3/R4 accept below capacity", disp_stall_o, 0);
      step();
    end
    disp_valid_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1
    chk(!iss_valid_o, "R1 no issue after reset", iss_valid_o, 0);
    chk(!mode_pack_o, "R1 blocking after reset", mode_pack_o, 0);
    disp(0, 1, 2, 1, 3, 1);
    chk(!disp_stall_o, "R1 empty queue accepts", disp_stall_o, 0);
    disp_valid_i = 0;

    // R2 R5 R10 sweep over threads and ready combinations
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 4; c++) begin
        logic r0, r1;
        int d;
        r0 = c[0]; r1 = c[1]; d = t * 4 + c;
        disp(t, d, 20, r0, 21, r1);
        chk(disp_stall_o == (!r0 && !r1), "R2 stall on two pending", disp_stall_o, !r0 && !r1);
        step();
        disp_valid_i = 0;
        if (r0 && r1) begin
          chk(iss_valid_o && iss_dst_o == 6'(d) && iss_tid_o == 2'(t), "R10 ready issues next cycle", iss_dst_o, d);
          step();
        end else if (r0 || r1) begin
          chk(!iss_valid_o, "R5 pending holds", iss_valid_o, 0);
          bcast(0, 33);
          chk(!iss_valid_o, "R5 other tag ignored", iss_valid_o, 0);
          bcast(c == 1 ? 1 : 0, r0 ? 21 : 20);
          chk(iss_valid_o && iss_dst_o == 6'(d), "R5 wake issues", iss_dst_o, d);
          step();
        end else begin
          chk(!iss_valid_o, "R2 stalled not stored", iss_valid_o, 0);
        end
      end

    // R2 same-cycle broadcast credit
    bc_valid_i = 2'b01; bc_tag0_i = 6'd24;
    disp(1, 9, 24, 0, 25, 0);
    chk(!disp_stall_o, "R2 same-cycle wake accepted", disp_stall_o, 0);
    step();
    disp_valid_i = 0; bc_valid_i = 0;
    chk(!iss_valid_o, "R2 second source still pending", iss_valid_o, 0);
    bcast(1, 25);
    chk(iss_valid_o && iss_dst_o == 6'd9, "R2 R5 wake on bus 1", iss_dst_o, 9);
    step();

    // R3 R6 blocking capacity and age order
    fill(32, 50);
    disp(0, 60, 1, 1, 2, 1);
    chk(disp_stall_o, "R3 stall when full in blocking", disp_stall_o, 1);
    disp_valid_i = 0;
    bcast(0, 50);
    for (int i = 0; i < 32; i++) begin
      chk(iss_valid_o && iss_dst_o == 6'(i), "R6 oldest first blocking", iss_dst_o, i);
      step();
    end
    chk(!iss_valid_o, "R6 drained", iss_valid_o, 0);

    // R8 mode change waits for empty
    disp(0, 7, 40, 0, 0, 1);
    step();
    disp_valid_i = 0;
    mode_pack_i = 1;
    disp(1, 8, 1, 1, 2, 1);
    chk(disp_stall_o, "R8 stall during mode change", disp_stall_o, 1);
    disp_valid_i = 0;
    step();
    chk(!mode_pack_o, "R8 mode held while occupied", mode_pack_o, 0);
    bcast(0, 40);
    chk(iss_valid_o && iss_dst_o == 6'd7, "R8 pending entry issues", iss_dst_o, 7);
    step();
    for (int k = 0; k < 5 && !mode_pack_o; k++) step();
    chk(mode_pack_o, "R8 mode switches when empty", mode_pack_o, 1);

    // R4 R6 packing capacity, mixed threads
    fill(64, 51);
    disp(0, 60, 1, 1, 2, 1);
    chk(disp_stall_o, "R4 stall when full in packing", disp_stall_o, 1);
    disp_valid_i = 0;
    bcast(1, 51);
    for (int i = 0; i < 64; i++) begin
      chk(iss_valid_o && iss_dst_o == 6'(i) && iss_tid_o == 2'(i % 4), "R4 R6 packed order", iss_dst_o, i);
      step();
    end

    // R9 flush one thread
    fill(8, 52);
    flush_valid_i = 1; flush_tid_i = 2;
    disp(2, 30, 1, 1, 2, 1);
    chk(disp_stall_o, "R9 flushed thread dispatch stalls", disp_stall_o, 1);
    disp_valid_i = 0;
    step();
    flush_valid_i = 0;
    bcast(0, 52);
    for (int i = 0; i < 8; i++) begin
      if (i % 4 == 2) continue;
      chk(iss_valid_o && iss_dst_o == 6'(i), "R9 survivors issue in order", iss_dst_o, i);
      step();
    end
    chk(!iss_valid_o, "R9 flushed never issue", iss_valid_o, 0);

    // R7 reuse of a freed slot
    fill(63, 53);
    disp(3, 63, 1, 1, 2, 1);
    step();
    disp(1, 44, 1, 1, 2, 1);
    chk(iss_valid_o && iss_dst_o == 6'd63, "R7 last slot issues", iss_dst_o, 63);
    chk(disp_stall_o, "R7 full before free", disp_stall_o, 1);
    step();
    chk(!disp_stall_o, "R7 freed slot accepts", disp_stall_o, 0);
    step();
    disp_valid_i = 0;
    chk(iss_valid_o && iss_dst_o == 6'd44, "R7 reused slot issues", iss_dst_o, 44);
    for (int t = 0; t < 4; t++) begin
      flush_valid_i = 1; flush_tid_i = 2'(t);
      step();
    end
    flush_valid_i = 0;
    bcast(0, 53);
    chk(!iss_valid_o, "R9 all threads flushed", iss_valid_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule